// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the command receiver of a page-buffered serial flash device, built entirely in the system clock domain. It synchronizes the chip-select, serial clock and serial data lines and detects their edges. It then frames each operation between a chip-select fall and the following chip-select rise. Each frame carries an 8-bit opcode and then a 24-bit address field, both sent most significant bit first. The top six address bits are reserved. The next nine bits select a page, and the lowest nine select a starting byte inside the 264-byte page buffer.

For the program-through-buffer opcode, every complete data byte that follows the address is written into the page buffer at once. The write position wraps from the last buffer byte back to byte 0. Three further opcodes carry only a page address: page-to-buffer transfer, page compare and auto page rewrite. For all four opcodes, a decoded command goes to the operation sequencer only when chip-select rises. The sequencer reads the buffer through a registered read port.

Top module: `sfc_frontend`

## Requirements
- R1: After reset, cmd_valid_o is low and no command is issued until a complete frame ends.
- R2: Bits are taken on SCK rising edges, MSB first. The first byte is the opcode, and the next three bytes form a 24-bit field. Bits 23..18 of that field are ignored, bits 17..9 are the page and bits 8..0 are the start byte.
- R3: For opcode 0x82, each complete data byte after the address is written into the buffer at consecutive positions, beginning at the start byte. A start byte of 264 to 511 is reduced by 264.
- R4: A buffer write that follows a write to byte 263 goes to byte 0.
- R5: When CS rises after the full 32-bit header, cmd_valid_o pulses for exactly one clock. cmd_kind_o is 0 for 0x82, 1 for 0x53, 2 for 0x60 and 3 for 0x58. cmd_page_o carries the page. cmd_start_o carries the normalized start byte for 0x82 and is 0 for the other three opcodes.
- R6: A CS rise before all 32 header bits have arrived issues no command and writes nothing.
- R7: A data byte with fewer than 8 bits at CS rise is discarded. The command itself is still issued.
- R8: An unrecognized opcode issues no command and writes no data bytes, whatever follows it before CS rises.
- R9: While CS is high, SCK and SI have no effect on the buffer or on commands.
- R10: The bit and byte counters restart at every CS fall, so a frame that follows an aborted frame decodes normally.
- R11: If the SCK rise carrying the last bit of a data byte reaches the block in the same clock as the CS rise, that byte is not written, and the command is still issued.
- R12: buf_rd_data_o shows the buffer byte at buf_rd_addr_i one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in, asynchronous |
| cmd_valid_o | output | 1 | One-clock pulse: decoded command ready |
| cmd_kind_o | output | 2 | Command code (see R5) |
| cmd_page_o | output | 9 | Page address of the command |
| cmd_start_o | output | 9 | Normalized start byte (program command only) |
| buf_rd_addr_i | input | 9 | Sequencer read address into the page buffer |
| buf_rd_data_o | output | 8 | Registered buffer read data |

## Verification
Two events can land in the same clock: the completion of a data byte, which writes the buffer, and the CS rise, which ends the frame and issues the command. The bench provokes this by raising SCK and CS in the same instant. Both signals pass through equal synchronizer depth, so their edge pulses coincide. The check expects the command with its page and start byte, and expects the buffer byte at the would-be write position to keep its previous value. A second overlap, a CS fall in the same clock as the first SCK rise, is handled by restarting the counters combinationally so that the bit is kept.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int OPC_W     = 8;
    localparam int HDR_BYTES = 4;
    localparam int FIELD_W   = 24;
    localparam int PAGE_W    = 9;
    localparam int START_W   = 9;
    localparam int BUF_DEPTH = 264;
    localparam int DATA_W    = 8;

    typedef enum logic [1:0] {
        KIND_PROG_BUF = 2'd0,
        KIND_XFER     = 2'd1,
        KIND_COMPARE  = 2'd2,
        KIND_REWRITE  = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [PAGE_W-1:0]    page;
        logic [START_W-1:0]   start;
    } cmd_t;

    typedef struct packed {
        logic      known;
        cmd_kind_e kind;
    } opc_dec_t;

    function automatic opc_dec_t decode_opcode(input logic [OPC_W-1:0] opc);
        opc_dec_t d;
        d.known = 1'b1;
        d.kind  = KIND_PROG_BUF;
        case (opc)
            8'h82:   d.kind = KIND_PROG_BUF;
            8'h53:   d.kind = KIND_XFER;
            8'h60:   d.kind = KIND_COMPARE;
            8'h58:   d.kind = KIND_REWRITE;
            default: d.known = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sfc_sync_edge.sv
module sfc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_n_s,
    output logic si_s,
    output logic sck_rise,
    output logic cs_fall,
    output logic cs_rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_pipe, sck_pipe, si_pipe;
    logic              cs_prev, sck_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_pipe[g]  <= 1'b1;
                    sck_pipe[g] <= 1'b0;
                    si_pipe[g]  <= 1'b0;
                end else if (g == 0) begin
                    cs_pipe[g]  <= cs_n_i;
                    sck_pipe[g] <= sck_i;
                    si_pipe[g]  <= si_i;
                end else begin
                    cs_pipe[g]  <= cs_pipe[(g == 0) ? 0 : g - 1];
                    sck_pipe[g] <= sck_pipe[(g == 0) ? 0 : g - 1];
                    si_pipe[g]  <= si_pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_pipe[LAST];
            sck_prev <= sck_pipe[LAST];
        end
    end

    assign cs_n_s   = cs_pipe[LAST];
    assign si_s     = si_pipe[LAST];
    assign sck_rise = sck_pipe[LAST] & ~sck_prev;
    assign cs_fall  = cs_prev & ~cs_pipe[LAST];
    assign cs_rise  = ~cs_prev & cs_pipe[LAST];

    // R2: every SCK rising edge yields a single-clock sampling pulse
    assert_sck_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/sfc_cmd_decoder.sv
module sfc_cmd_decoder
    import sfc_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int HCW  = $clog2(HDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              si_s,
    input  logic              sck_rise,
    input  logic              cs_fall,
    input  logic              cs_rise,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_valid,
    output cmd_t              cmd
);
    localparam logic [AW-1:0]  LAST_POS = AW'(DEPTH - 1);
    localparam logic [HCW-1:0] HDR_DONE = HCW'(HDR_BYTES);

    logic [DATA_W-1:0]  shreg;
    logic [2:0]         bit_cnt;
    logic [HCW-1:0]     hdr_cnt;
    logic [OPC_W-1:0]   opcode_q;
    logic [FIELD_W-1:0] field_q;
    logic [PAGE_W-1:0]  page_q;
    logic [START_W-1:0] start_q;
    logic [AW-1:0]      wr_ptr;
    logic               cmd_valid_q;
    cmd_t               cmd_q;

    logic [2:0]         cur_bit;
    logic [HCW-1:0]     cur_hdr;
    logic               take, byte_done;
    logic [DATA_W-1:0]  byte_now;
    logic [FIELD_W-1:0] field_next;
    logic [START_W-1:0] start_raw, start_norm;
    opc_dec_t           dec;

    // a CS fall restarts the frame in the same clock it is seen
    assign cur_bit    = cs_fall ? 3'd0 : bit_cnt;
    assign cur_hdr    = cs_fall ? '0 : hdr_cnt;
    assign take       = sck_rise & ~cs_n_s;
    assign byte_now   = {shreg[DATA_W-2:0], si_s};
    assign byte_done  = take && (cur_bit == 3'd7);
    assign field_next = {field_q[FIELD_W-9:0], byte_now};
    assign start_raw  = field_next[START_W-1:0];
    assign start_norm = (start_raw >= START_W'(DEPTH)) ? start_raw - START_W'(DEPTH) : start_raw;
    assign dec        = decode_opcode(opcode_q);

    assign wr_en   = byte_done && (cur_hdr == HDR_DONE) && dec.known && (dec.kind == KIND_PROG_BUF);
    assign wr_addr = wr_ptr;
    assign wr_data = byte_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg       <= '0;
            bit_cnt     <= '0;
            hdr_cnt     <= '0;
            opcode_q    <= '0;
            field_q     <= '0;
            page_q      <= '0;
            start_q     <= '0;
            wr_ptr      <= '0;
            cmd_valid_q <= 1'b0;
            cmd_q       <= '0;
        end else begin
            cmd_valid_q <= 1'b0;
            if (cs_fall) begin
                bit_cnt <= '0;
                hdr_cnt <= '0;
            end
            if (take) begin
                shreg   <= byte_now;
                bit_cnt <= 3'(cur_bit + 3'd1);
                if (byte_done) begin
                    if (cur_hdr == '0) begin
                        opcode_q <= byte_now;
                        hdr_cnt  <= HCW'(1);
                    end else if (cur_hdr < HDR_DONE) begin
                        field_q <= field_next;
                        hdr_cnt <= HCW'(cur_hdr + HCW'(1));
                        if (cur_hdr == HDR_DONE - HCW'(1)) begin
                            page_q  <= field_next[START_W +: PAGE_W];
                            start_q <= start_norm;
                            wr_ptr  <= AW'(start_norm);
                        end
                    end else if (wr_en) begin
                        wr_ptr <= (wr_ptr == LAST_POS) ? '0 : AW'(wr_ptr + AW'(1));
                    end
                end
            end
            if (cs_rise) begin
                cmd_valid_q <= (hdr_cnt == HDR_DONE) && dec.known;
                cmd_q.kind  <= dec.kind;
                cmd_q.page  <= page_q;
                cmd_q.start <= (dec.kind == KIND_PROG_BUF) ? start_q : '0;
            end
        end
    end

    assign cmd_valid = cmd_valid_q;
    assign cmd       = cmd_q;

    // R4: a write never addresses beyond the last buffer byte
    assert_wr_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr <= LAST_POS));

    // R4: after writing the last byte, the next write position is byte 0
    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == LAST_POS) |=> (wr_addr == '0));

    // R9: nothing is written while the synchronized CS is high
    assert_no_wr_cs_high_R9: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |-> !wr_en);

    // R5: the command strobe lasts one clock
    assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R5: a command appears only right after a CS rise
    assert_cmd_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cs_rise));

endmodule

// File: rtl/sfc_page_buffer.sv
module sfc_page_buffer
    import sfc_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < AW'(DEPTH)))
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_addr < AW'(DEPTH))
            rd_data <= mem[rd_addr];
        else
            rd_data <= '0;
    end

endmodule

// File: rtl/sfc_frontend.sv
module sfc_frontend
    import sfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n_i,
    input  logic                sck_i,
    input  logic                si_i,
    output logic                cmd_valid_o,
    output logic [1:0]          cmd_kind_o,
    output logic [PAGE_W-1:0]   cmd_page_o,
    output logic [START_W-1:0]  cmd_start_o,
    input  logic [START_W-1:0]  buf_rd_addr_i,
    output logic [DATA_W-1:0]   buf_rd_data_o
);
    localparam int AW = $clog2(BUF_DEPTH);

    logic              cs_n_s, si_s, sck_rise, cs_fall, cs_rise;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [DATA_W-1:0] wr_data;
    cmd_t              cmd;

    sfc_sync_edge #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .cs_n_i   (cs_n_i),
        .sck_i    (sck_i),
        .si_i     (si_i),
        .cs_n_s   (cs_n_s),
        .si_s     (si_s),
        .sck_rise (sck_rise),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise)
    );

    sfc_cmd_decoder #(.DEPTH(BUF_DEPTH)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (cs_n_s),
        .si_s      (si_s),
        .sck_rise  (sck_rise),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmd_valid (cmd_valid_o),
        .cmd       (cmd)
    );

    sfc_page_buffer #(.DEPTH(BUF_DEPTH), .DW(DATA_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (AW'(buf_rd_addr_i)),
        .rd_data (buf_rd_data_o)
    );

    assign cmd_kind_o  = cmd.kind;
    assign cmd_page_o  = cmd.page;
    assign cmd_start_o = cmd.start;

    // R5: page-only commands report a zero start byte
    assert_page_only_start_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_kind_o != 2'd0) |-> (cmd_start_o == '0));

    // R1: no command strobe in the clock after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !cmd_valid_o);

endmodule

// File: tb/sfc_frontend_tb.sv
module sfc_frontend_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int DEPTH      = 264;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic       cmd_valid;
    logic [1:0] cmd_kind;
    logic [8:0] cmd_page, cmd_start, rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0, fails = 0;
    int n_cmd = 0;
    int last_kind = 0, last_page = 0, last_start = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    sfc_frontend dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .cmd_page_o(cmd_page),
        .cmd_start_o(cmd_start), .buf_rd_addr_i(rd_addr), .buf_rd_data_o(rd_data)
    );

    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            n_cmd++;
            last_kind  = int'(cmd_kind);
            last_page  = int'(cmd_page);
            last_start = int'(cmd_start);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int norm_start(input int s);
        return (s >= DEPTH) ? s - DEPTH : s;
    endfunction

    function automatic int kind_of(input int opc);
        case (opc)
            'h82: return 0;
            'h53: return 1;
            'h60: return 2;
            'h58: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic send_bit(input logic b);
        si = b;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_header(input int opc, input int page, input int start);
        logic [23:0] f;
        f = {6'($urandom), 9'(page), 9'(start)};
        send_byte(8'(opc));
        send_byte(f[23:16]);
        send_byte(f[15:8]);
        send_byte(f[7:0]);
    endtask

    task automatic check_buffer(input string req);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            rd_addr = 9'(a);
            @(negedge clk);
            if (rd_data !== model[a]) begin
                bad++;
                if (bad <= 4)
                    $display("FAIL %s: byte %0d actual %0d expected %0d", req, a, rd_data, model[a]);
            end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    // program-through-buffer frame with n data bytes, updates the model
    task automatic prog_frame(input int page, input int start, input int n, input string req);
        int p, c0;
        logic [7:0] d;
        c0 = n_cmd;
        frame_begin();
        send_header('h82, page, start);
        p = norm_start(start);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d);
            model[p] = d;
            p = (p == DEPTH - 1) ? 0 : p + 1;
        end
        frame_end();
        chk({req, " cmd count"}, n_cmd - c0, 1);
        chk({req, " kind"}, last_kind, 0);
        chk({req, " page"}, last_page, page);
        chk({req, " start"}, last_start, norm_start(start));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int c0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk("R1 cmd_valid during reset", int'(cmd_valid), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 cmd_valid after reset", int'(cmd_valid), 0);
        chk("R1 no command after reset", n_cmd, 0);

        // R3 R4: fill the whole buffer from byte 100, wrapping past 263
        prog_frame(9'h1A5, 100, DEPTH, "R4 full wrap");
        check_buffer("R4 buffer after full wrap");

        // R12: read latency of one clock
        @(negedge clk); rd_addr = 9'd5;
        @(negedge clk);
        chk("R12 read data one clock later", int'(rd_data), int'(model[5]));

        // R3: start byte above 263 is reduced by 264
        prog_frame(9'h003, 300, 5, "R3 start reduce");
        check_buffer("R3 buffer after reduced start");

        // R5 R2: page-only commands, random reserved bits
        foreach (model[k]) begin end
        begin
            int opcs [3] = '{'h53, 'h60, 'h58};
            for (int i = 0; i < 3; i++) begin
                int pg;
                pg = int'($urandom_range(0, 511));
                c0 = n_cmd;
                frame_begin();
                send_header(opcs[i], pg, int'($urandom_range(0, 511)));
                frame_end();
                chk("R5 page-only cmd count", n_cmd - c0, 1);
                chk("R5 page-only kind", last_kind, kind_of(opcs[i]));
                chk("R2 page-only page", last_page, pg);
                chk("R5 page-only start zero", last_start, 0);
            end
        end

        // R6: abort after 20 bits, then R10: next frame decodes normally
        c0 = n_cmd;
        frame_begin();
        send_byte(8'h82);
        send_byte(8'h00);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        frame_end();
        chk("R6 no command on short header", n_cmd - c0, 0);
        check_buffer("R6 buffer untouched by aborted frame");
        prog_frame(9'h0F0, 10, 3, "R10 frame after abort");
        check_buffer("R10 buffer after frame following abort");

        // R7: a partial data byte is discarded
        frame_begin();
        send_header('h82, 9'h011, 40);
        send_byte(8'hC3);
        model[40] = 8'hC3;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        c0 = n_cmd;
        frame_end();
        chk("R7 command issued with partial byte", n_cmd - c0, 1);
        check_buffer("R7 partial byte not written");

        // R8: unknown opcode with trailing data
        c0 = n_cmd;
        frame_begin();
        send_header('h11, 9'h022, 0);
        for (int i = 0; i < 6; i++) send_byte(8'hA5);
        frame_end();
        chk("R8 unknown opcode issues nothing", n_cmd - c0, 0);
        check_buffer("R8 unknown opcode writes nothing");

        // R9: toggling SCK and SI while CS is high
        c0 = n_cmd;
        for (int i = 0; i < 40; i++) send_bit(1'($urandom));
        repeat (8) @(negedge clk);
        chk("R9 no command while deselected", n_cmd - c0, 0);
        check_buffer("R9 buffer unchanged while deselected");

        // R11: last data bit SCK rise coincides with CS rise
        c0 = n_cmd;
        frame_begin();
        send_header('h82, 9'h155, 200);
        send_byte(8'h5A);
        model[200] = 8'h5A;
        begin
            logic [7:0] d = 8'hFF ^ model[201];
            for (int i = 7; i >= 1; i--) send_bit(d[i]);
            si = d[0];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            cs_n = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            repeat (8) @(negedge clk);
        end
        chk("R11 command still issued", n_cmd - c0, 1);
        chk("R11 command page", last_page, 'h155);
        check_buffer("R11 coinciding byte not written");

        // random program frames, some long enough to wrap (R3 R4)
        for (int r = 0; r < 4; r++) begin
            prog_frame(int'($urandom_range(0, 511)), int'($urandom_range(0, 511)),
                       int'($urandom_range(0, 290)), "R3 random program");
            check_buffer("R3 random buffer contents");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule